// File: doc/BRIEF.md
# Keyed Register Write Lock

This block guards a peripheral register bank against stray writes. It watches every write on the register bus. Two word addresses act as lock registers: the primary at byte offset 0x00 and the secondary at byte offset 0x7c. While the bank is unlocked, a write of any value to either lock register engages the lock. While the lock is engaged, the block holds its write-permit output low for every protected address, so the register file drops those writes. Addresses outside the protected set still pass, so status clears and reads of input data keep working.

Releasing the lock takes an ordered two-word key. First the value `KEY_FIRST` (default 0xc0de1248) goes to the secondary lock register. Then the value `KEY_SECOND` (default 0xc0defa73) goes to the primary lock register. Between the two key writes, writes to other addresses leave the pending half of the key intact. Any other write to a lock register clears it.

The write port is a single-cycle strobe. The block never stalls it, so it has no ready and no back-pressure. `wr_permit` is combinational from the current write and the current lock state. The `locked` output is the readable lock bit and changes one cycle after the write that causes the change. Reads need no gating and do not pass through the block.

Top module: `wlock_guard`

## Requirements
- R1: After reset, `locked` is 0 and no half-completed key is pending: a lone `KEY_SECOND` write to 0x00 then engages the lock instead of unlocking.
- R2: While unlocked, a write of any value to byte address 0x00 sets `locked` to 1 on the next cycle.
- R3: While unlocked, a write of any value to byte address 0x7c sets `locked` to 1 on the next cycle. This includes the value `KEY_FIRST`.
- R4: While `locked` is 1, `wr_permit` is 0 for a write to any protected address. While `locked` is 0, `wr_permit` is 1 for every valid write that does not target a lock register. Word index i (byte address 4*i) is protected when bit i of `PROT_MASK` is 1. The default mask is 0x7FF7FFFC.
- R5: While locked, writing `KEY_FIRST` to 0x7c and then `KEY_SECOND` to 0x00 clears `locked` on the cycle after the second write.
- R6: While locked, any other write to a lock register clears the pending first key and leaves `locked` at 1. This covers a wrong value, a second key without a first, a first key written to 0x00, and a repeated write to 0x7c with a wrong value.
- R7: A write to a non-lock address between the two key writes keeps the pending first key, so the unlock still completes.
- R8: `wr_permit` is 0 for every write to a lock register. It is 1 for every valid write to an unprotected address (by default 0x04 and 0x4c) regardless of `locked`. With `wr_valid` low, `wr_permit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Register-bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W (7) | Byte address of the write |
| wr_data | input | 32 | Write data |
| wr_permit | output | 1 | The register file may commit this write |
| locked | output | 1 | Lock state: 1 locked, 0 unlocked |

## Verification
The bench goes after these corner cases:

- **Key order.** It writes the keys in the wrong order and sends the second key on its own. A design that unlocked on either key alone, or in either order, would drop `locked` where the model keeps it high.
- **Re-arming.** It writes the first key twice, and a wrong value after the first key. A design that let the pending key survive a bad lock-register write would unlock early.
- **Interleaved writes.** It interleaves unrelated writes between the two keys. A design that reset the sequence on any write would stay locked.
- **Unprotected addresses and lock registers.** It checks that unprotected addresses pass while locked and that lock-register writes never reach the register file.
- **Random traffic.** Random traffic dense in lock addresses and key values covers mixes that the directed cases miss.

// File: rtl/wlock_pkg.sv
package wlock_pkg;
  typedef struct packed {
    logic hit_pri;   // primary lock register
    logic hit_sec;   // secondary lock register
    logic prot;      // address in protected set
  } wlock_dec_t;
endpackage

// File: rtl/wlock_addr_dec.sv
module wlock_addr_dec #(
  parameter int ADDR_W = 7,
  parameter int PRI_OFS = 0,
  parameter int SEC_OFS = 124,
  parameter logic [(1 << (ADDR_W - 2)) - 1 : 0] PROT_MASK = '1
) (
  input  logic [ADDR_W-1:0] addr,
  output wlock_pkg::wlock_dec_t dec
);
  localparam int WIDX_W = ADDR_W - 2;
  localparam int NWORDS = 1 << WIDX_W;
  localparam logic [WIDX_W-1:0] PRI_W = WIDX_W'(PRI_OFS / 4);
  localparam logic [WIDX_W-1:0] SEC_W = WIDX_W'(SEC_OFS / 4);

  logic [WIDX_W-1:0] widx;
  logic [NWORDS-1:0] onehot;

  assign widx = addr[ADDR_W-1:2];

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    assign onehot[i] = (widx == WIDX_W'(i));
  end

  always_comb begin
    dec.hit_pri = (widx == PRI_W);
    dec.hit_sec = (widx == SEC_W);
    dec.prot    = |(onehot & PROT_MASK);
  end
endmodule

// File: rtl/wlock_seq.sv
module wlock_seq #(
  parameter logic [31:0] KEY_FIRST = 32'hc0de1248,
  parameter logic [31:0] KEY_SECOND = 32'hc0defa73
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  input  logic [31:0] wr_data,
  input  wlock_pkg::wlock_dec_t dec,
  output logic        locked
);
  logic armed;
  logic key1_ok, key2_ok;

  assign key1_ok = (wr_data == KEY_FIRST);
  assign key2_ok = (wr_data == KEY_SECOND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      armed  <= 1'b0;
    end else if (wr_valid && dec.hit_sec) begin
      locked <= 1'b1;
      armed  <= locked && key1_ok;
    end else if (wr_valid && dec.hit_pri) begin
      locked <= !(locked && armed && key2_ok);
      armed  <= 1'b0;
    end
  end
endmodule

// File: rtl/wlock_gate.sv
module wlock_gate (
  input  logic wr_valid,
  input  logic locked,
  input  wlock_pkg::wlock_dec_t dec,
  output logic wr_permit
);
  logic lock_reg;
  assign lock_reg  = dec.hit_pri | dec.hit_sec;
  assign wr_permit = wr_valid & ~lock_reg & ~(locked & dec.prot);
endmodule

// File: rtl/wlock_guard.sv
module wlock_guard #(
  parameter int ADDR_W = 7,
  parameter logic [31:0] KEY_FIRST = 32'hc0de1248,
  parameter logic [31:0] KEY_SECOND = 32'hc0defa73,
  parameter logic [(1 << (ADDR_W - 2)) - 1 : 0] PROT_MASK = 32'h7FF7FFFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic              wr_permit,
  output logic              locked
);
  wlock_pkg::wlock_dec_t dec;

  wlock_addr_dec #(
    .ADDR_W(ADDR_W), .PRI_OFS(0), .SEC_OFS(124), .PROT_MASK(PROT_MASK)
  ) u_dec (
    .addr(wr_addr), .dec(dec)
  );

  wlock_seq #(
    .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .dec(dec), .locked(locked)
  );

  wlock_gate u_gate (
    .wr_valid(wr_valid), .locked(locked), .dec(dec), .wr_permit(wr_permit)
  );
endmodule

// File: rtl/wlock_guard_chk.sv
module wlock_guard_chk #(
  parameter int ADDR_W = 7,
  parameter logic [31:0] KEY_SECOND = 32'hc0defa73,
  parameter logic [(1 << (ADDR_W - 2)) - 1 : 0] PROT_MASK = 32'h7FF7FFFC
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic              wr_permit,
  input logic              locked
);
  logic [ADDR_W-3:0] w;
  logic is_pri, is_sec, is_prot;
  assign w       = wr_addr[ADDR_W-1:2];
  assign is_pri  = (w == '0);
  assign is_sec  = (w == '1);
  assign is_prot = PROT_MASK[w];

  AST_LOCK_BY_PRI: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && is_pri && !locked) |=> locked); // R2
  AST_LOCK_BY_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && is_sec) |=> locked); // R3
  AST_BLOCK_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && locked && is_prot) |-> !wr_permit); // R4
  AST_UNLOCK_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(wr_valid && is_pri && wr_data == KEY_SECOND)); // R5
  AST_LOCKREG_NOPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && (is_pri || is_sec)) |-> !wr_permit); // R8
  AST_UNPROT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !is_prot && !is_pri && !is_sec) |-> wr_permit); // R8
endmodule

bind wlock_guard wlock_guard_chk #(
  .ADDR_W(ADDR_W), .KEY_SECOND(KEY_SECOND), .PROT_MASK(PROT_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .wr_data(wr_data), .wr_permit(wr_permit), .locked(locked)
);

// File: tb/wlock_guard_tb.sv
module wlock_guard_tb;
  localparam logic [31:0] KA = 32'hc0de1248;
  localparam logic [31:0] KB = 32'hc0defa73;
  localparam logic [31:0] PMASK = 32'h7FF7FFFC;

  logic clk = 0, rst_n = 0, wr_valid = 0;
  logic [6:0] wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic wr_permit, locked;
  int total = 0, bad = 0;
  bit m_lock = 0, m_arm = 0;

  always #2 clk = ~clk;

  wlock_guard u_dut (.clk(clk), .rst_n(rst_n), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_permit(wr_permit), .locked(locked));

  function automatic bit exp_permit(bit v, logic [6:0] a, bit lk);
    logic [4:0] w = a[6:2];
    if (!v || w == 0 || w == 31) return 0;
    return !(lk && PMASK[w]);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(bit v, logic [6:0] a, logic [31:0] d, string req);
    @(negedge clk);
    wr_valid = v; wr_addr = a; wr_data = d;
    #1 chk({req, " permit"}, {31'b0, wr_permit}, {31'b0, exp_permit(v, a, m_lock)});
    if (v && a[6:2] == 31) begin
      m_arm = m_lock && d == KA; m_lock = 1;
    end else if (v && a[6:2] == 0) begin
      m_lock = !(m_lock && m_arm && d == KB); m_arm = 0;
    end
    @(posedge clk); #1;
    wr_valid = 0;
    chk({req, " locked"}, {31'b0, locked}, {31'b0, m_lock});
  endtask

  initial begin
    #20000000;
    bad++; total++;
    $display("FAIL watchdog act=hang exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", {31'b0, locked}, 0);
    rst_n = 1;
    wr(1, 7'h08, 32'h1, "R4 unlocked pass");
    wr(1, 7'h00, KB, "R1 lone second key locks");
    wr(1, 7'h08, 32'h2, "R4 blocked");
    wr(1, 7'h04, 32'h3, "R8 din pass");
    wr(1, 7'h4c, 32'h4, "R8 evst pass");
    wr(1, 7'h7c, KA, "R5 key1");
    wr(1, 7'h00, KB, "R5 key2");
    chk("R5 unlocked", {31'b0, locked}, 0);
    wr(1, 7'h7c, KA, "R3 sec locks even with key");
    wr(1, 7'h00, KB, "R6 no pending after locking write");
    wr(1, 7'h00, KA, "R6 key1 to pri");
    wr(1, 7'h7c, KA, "R6 key1");
    wr(1, 7'h7c, 32'h0, "R6 wrong sec clears");
    wr(1, 7'h00, KB, "R6 stays locked");
    wr(1, 7'h7c, KA, "R7 key1");
    wr(1, 7'h10, 32'h5, "R7 other write");
    wr(0, 7'h00, 32'h0, "R8 idle");
    wr(1, 7'h00, KB, "R7 unlock after gap");
    wr(1, 7'h00, 32'h0, "R2 pri locks");
    wr(1, 7'h7c, KA, "R2 prep");
    wr(1, 7'h00, KB, "R5 unlock again");
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom % 10;
      logic [6:0] a = (r < 3) ? 7'h00 : (r < 6) ? 7'h7c : 7'(($urandom % 32) * 4);
      logic [31:0] d = ($urandom % 5 == 0) ? $urandom : (($urandom % 2) ? KA : KB);
      wr($urandom % 8 != 0, a, d, "R4 R5 R6 random");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule